// File: doc/BRIEF.md
# Crystal-Derived Bit Clock and Reference Clock Generator

This block turns the crystal clock into the timing a low-rate transmitter needs. A programmable prescaler divides the crystal by an integer K. Its output is a one-cycle modulator tick. A second stage divides that tick by a power of two, 2^(3+n), to form the bit period. The bit period appears on a data clock pin when the synchronous data mode is on. A free-running divide-by-16 gives a reference clock for a host controller, and that output can be gated off.

In synchronous mode the host changes its data bit while the data clock is low. The block captures the bit on the rising edge of the data clock and holds it for one whole bit period. In asynchronous mode the data clock stays low and the data bit passes straight through.

A new K or exponent takes effect only at the end of the current bit period. This means a setting change never cuts a data clock pulse short. All state is clocked by the crystal clock, so "one cycle" below means one crystal period.

Top module: `xtal_rate_gen`

## Requirements
- R1: `mod_tick_o` is a one-cycle pulse that repeats every K crystal cycles, where K is the active divide factor.
- R2: With `sync_en_i` = 1, `dclk_o` repeats every K·2^(3+n) cycles. In each period it is low for the first half and high for the second half, so the duty cycle is exactly 50 %.
- R3: With `sync_en_i` = 0, `dclk_o` is low from the next cycle on, and `data_o` equals `data_i` in the same cycle.
- R4: With `sync_en_i` = 1, `data_o` takes the value `data_i` had at the clock edge where `dclk_o` rises. It holds that value until the next rise.
- R5: With `ref_en_i` = 1 and `sleep_i` = 0, `ref_clk_o` is the crystal divided by 16. Counting edges since reset release, it is high during cycles 8 to 15 of every 16.
- R6: `ref_clk_o` is low in the same cycle in which `ref_en_i` is 0 or `sleep_i` is 1.
- R7: A `div_k_i` of 0 acts as K = 1. An `exp_i` of 6 or 7 acts as n = 5.
- R8: `div_k_i` and `exp_i` are loaded only in the last cycle of a bit period. Both counters then restart, and `dclk_o` begins the new period low.
- R9: Reset gives K = 1, n = 0, all counters at zero, and `mod_tick_o`, `dclk_o` and `ref_clk_o` low. The held data bit is also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_k_i | input | 6 | Prescaler factor K (0 treated as 1) |
| exp_i | input | 3 | Bit-rate exponent n (above 5 treated as 5) |
| sync_en_i | input | 1 | 1: synchronous data with data clock; 0: transparent data |
| ref_en_i | input | 1 | Enables the divide-by-16 reference output |
| sleep_i | input | 1 | Forces the reference output low |
| data_i | input | 1 | Serial data from the host |
| mod_tick_o | output | 1 | Modulator clock tick, one cycle wide |
| dclk_o | output | 1 | Data clock |
| ref_clk_o | output | 1 | Reference clock output |
| data_o | output | 1 | Captured or passed-through data bit |

## Verification
Two events can land in the same cycle: the last cycle of a bit period, and the loading of a new K and exponent. That cycle is also the one in which `dclk_o` falls and both counters wrap. The bench provokes this by changing K and n partway through a period, and by setting illegal values that must be clamped. A behavioural model tracks one flat phase counter per bit period, loads its settings only when that counter wraps, and is compared with every output on every cycle. Data capture on the rising edge is judged against freshly randomised input bits each cycle, so a capture that is one edge early or late shows up as a mismatch.

// File: rtl/xrg_pkg.sv
package xrg_pkg;
    localparam int KW       = 6;                 // prescaler factor width
    localparam int EW       = 3;                 // exponent field width
    localparam int NMAX     = 5;                 // largest legal exponent
    localparam int BASE_LOG = 3;                 // fixed 2^3 stage
    localparam int BCW      = BASE_LOG + NMAX;   // bit counter width
    localparam int REF_LOG  = 4;                 // reference divide 2^4

    typedef struct packed {
        logic [KW-1:0] k;
        logic [EW-1:0] n;
    } cfg_t;

    function automatic cfg_t clamp_cfg(logic [KW-1:0] k, logic [EW-1:0] n);
        cfg_t r;
        r.k = (k == '0) ? KW'(1) : k;
        r.n = (n > EW'(NMAX)) ? EW'(NMAX) : n;
        return r;
    endfunction
endpackage

// File: rtl/xrg_prescale.sv
module xrg_prescale
    import xrg_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [KW-1:0] k_i,
    output logic          last_o,
    output logic          tick_o
);
    typedef struct packed {
        logic [KW-1:0] cnt;
        logic          tick;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        last_o   = (s_q.cnt == k_i - KW'(1));
        s_d      = s_q;
        s_d.tick = last_o;
        s_d.cnt  = last_o ? '0 : s_q.cnt + KW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign tick_o = s_q.tick;

    // R1: the phase count never reaches the active factor
    a_r1_cnt_below_k: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt < k_i);
endmodule

// File: rtl/xrg_bitdiv.sv
module xrg_bitdiv
    import xrg_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          step_i,
    input  logic [EW-1:0] n_i,
    input  logic          sync_en_i,
    output logic          wrap_o,
    output logic          rise_o,
    output logic          dclk_o
);
    typedef struct packed {
        logic [BCW-1:0] cnt;
        logic           dclk;
    } st_t;

    st_t            s_d, s_q;
    logic [BCW-1:0] lim;
    logic [BCW-1:0] half;
    logic           at_end;

    always_comb begin
        lim    = {BCW{1'b1}} >> (EW'(NMAX) - n_i);
        half   = (lim >> 1) + BCW'(1);
        at_end = (s_q.cnt == lim);
        wrap_o = step_i && at_end;
        s_d    = s_q;
        if (step_i) s_d.cnt = at_end ? '0 : s_q.cnt + BCW'(1);
        s_d.dclk = sync_en_i && (s_d.cnt >= half);
        rise_o   = s_d.dclk && !s_q.dclk;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign dclk_o = s_q.dclk;

    // R2: tick counter stays inside the current period
    a_r2_cnt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.cnt <= lim);
    // R8: every new period starts with the data clock low
    a_r8_low_after_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_o |=> !dclk_o);
    // R3: asynchronous mode silences the data clock
    a_r3_idle_when_async: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sync_en_i |=> !dclk_o);
endmodule

// File: rtl/xrg_refdiv.sv
module xrg_refdiv
    import xrg_pkg::*;
#(
    parameter int LOG = REF_LOG
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic sleep_i,
    output logic ref_o
);
    typedef struct packed {
        logic [LOG-1:0] cnt;
    } st_t;

    st_t  s_d, s_q;
    logic gate;

    always_comb begin
        s_d.cnt = s_q.cnt + LOG'(1);
        gate    = en_i && !sleep_i;
        ref_o   = gate && s_q.cnt[LOG-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // R5: the enabled output only moves at half-period boundaries
    a_r5_stable_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gate && $past(gate) && s_q.cnt[LOG-2:0] != '0) |-> $stable(ref_o));
endmodule

// File: rtl/xtal_rate_gen.sv
module xtal_rate_gen
    import xrg_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [KW-1:0] div_k_i,
    input  logic [EW-1:0] exp_i,
    input  logic          sync_en_i,
    input  logic          ref_en_i,
    input  logic          sleep_i,
    input  logic          data_i,
    output logic          mod_tick_o,
    output logic          dclk_o,
    output logic          ref_clk_o,
    output logic          data_o
);
    typedef struct packed {
        cfg_t cfg;
        logic data;
    } st_t;

    st_t  s_d, s_q;
    logic pre_last;
    logic wrap;
    logic rise;

    xrg_prescale u_pre (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .k_i    (s_q.cfg.k),
        .last_o (pre_last),
        .tick_o (mod_tick_o)
    );

    xrg_bitdiv u_bit (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (pre_last),
        .n_i       (s_q.cfg.n),
        .sync_en_i (sync_en_i),
        .wrap_o    (wrap),
        .rise_o    (rise),
        .dclk_o    (dclk_o)
    );

    xrg_refdiv #(.LOG(REF_LOG)) u_ref (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (ref_en_i),
        .sleep_i (sleep_i),
        .ref_o   (ref_clk_o)
    );

    always_comb begin
        s_d = s_q;
        if (wrap) s_d.cfg  = clamp_cfg(div_k_i, exp_i);
        if (rise) s_d.data = data_i;
        data_o = sync_en_i ? s_q.data : data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.cfg.k <= KW'(1);
            s_q.cfg.n <= '0;
            s_q.data  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R7: the active settings are always legal
    a_r7_cfg_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.cfg.k != '0) && (s_q.cfg.n <= EW'(NMAX)));
    // R4: in synchronous mode the bit only changes on a data clock rise
    a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_en_i && $past(sync_en_i) && !$rose(dclk_o)) |-> $stable(data_o));
endmodule

// File: tb/xtal_rate_gen_tb_top.sv
`timescale 1ns/1ps
module xtal_rate_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] div_k = 6'd0;
    logic [2:0] expn = 3'd0;
    logic       sync_en = 1'b0, ref_en = 1'b0, sleep = 1'b0, data_in = 1'b0;
    logic       mod_tick, dclk, ref_clk, data_out;

    int    checks = 0, errors = 0;
    bit    running = 0, rand_data = 0, finished = 0;
    string scen = "R9";

    always #2.5 clk = ~clk;

    xtal_rate_gen dut_i (
        .clk_i(clk), .rst_ni(rst_n), .div_k_i(div_k), .exp_i(expn),
        .sync_en_i(sync_en), .ref_en_i(ref_en), .sleep_i(sleep), .data_i(data_in),
        .mod_tick_o(mod_tick), .dclk_o(dclk), .ref_clk_o(ref_clk), .data_o(data_out)
    );

    // behavioural model: flat phase within one bit period
    int mk, mn, ph, c16;
    bit e_tick, e_dclk, e_data;

    always @(posedge clk) begin
        if (!rst_n) begin
            mk = 1; mn = 0; ph = 0; c16 = 0;
            e_tick = 0; e_dclk = 0; e_data = 0;
        end else begin
            int per;
            bit nd;
            per    = mk * (8 << mn);
            e_tick = (ph % mk) == (mk - 1);
            if (ph == per - 1) begin
                ph = 0;
                mk = (div_k == 0) ? 1 : int'(div_k);
                mn = (expn > 5) ? 5 : int'(expn);
            end else begin
                ph = ph + 1;
            end
            nd = sync_en && (ph >= per / 2);
            if (nd && !e_dclk) e_data = data_in;
            e_dclk = nd;
            c16 = (c16 + 1) % 16;
        end
    end

    always @(posedge clk) if (rand_data) begin
        #1 data_in = 1'($urandom_range(1, 0));
    end

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (scenario %s) actual=%0b expected=%0b at %0t", req, scen, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (running && rst_n) begin
        bit on;
        on = ref_en && !sleep;
        chk("R1", mod_tick, e_tick);
        chk(sync_en ? "R2" : "R3", dclk, e_dclk);
        chk(sync_en ? "R4" : "R3", data_out, sync_en ? e_data : data_in);
        chk(on ? "R5" : "R6", ref_clk, on && ((c16 >> 3) & 1));
    end

    task automatic setup(string s, int k, int n, bit sy, bit re, bit sl, int cycles);
        @(posedge clk); #1;
        scen = s; div_k = 6'(k); expn = 3'(n);
        sync_en = sy; ref_en = re; sleep = sl;
        repeat (cycles) @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", mod_tick, 1'b0);
        chk("R9", dclk, 1'b0);
        chk("R9", ref_clk, 1'b0);
        chk("R9", data_out, 1'b0);
        @(posedge clk); #1;
        rst_n = 1; running = 1; rand_data = 1;
        setup("R2", 3, 0, 1, 1, 0, 300);
        setup("R1", 1, 1, 1, 1, 0, 200);
        setup("R8", 5, 2, 1, 1, 0, 37);
        setup("R8", 2, 0, 1, 1, 0, 400);
        setup("R7", 0, 7, 1, 1, 0, 700);
        setup("R7", 0, 6, 1, 1, 0, 300);
        setup("R3", 4, 0, 0, 1, 0, 200);
        setup("R6", 4, 0, 0, 0, 0, 100);
        setup("R6", 4, 0, 1, 1, 1, 100);
        setup("R5", 4, 0, 1, 1, 0, 100);
        setup("R4", 63, 0, 1, 1, 0, 1100);
        setup("R4", 2, 5, 1, 1, 0, 1100);
        @(negedge clk);
        running = 0;
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog expired (scenario %s) actual=running expected=done", scen);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule